// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block is the device-side command interpreter for the erase path of a flash memory. It watches the write cycles on the memory bus, each given as one clock with the write strobe high together with an address and a data byte. It recognises two six-write sequences: one that erases the whole array and one that erases chosen sectors. The erase itself is modelled as a cycle counter, because the storage array is not part of this block.

After a sector-erase command, an acceptance window opens. Each further sector-erase write in that window adds a sector to the set and starts the window again. Any other write in the window abandons the request. Once the window runs out, erasing begins. While a sector erase is running, only the suspend command has an effect, and that effect is limited to raising a flag. While a chip erase is running, every write is ignored.

The status outputs are a ready/busy line, a bit showing that the timed erase phase is underway, a read-array indication and the latched sector set. Bus masters poll these outputs to find out when the operation has finished.

Top module: `flash_erase_decoder`

## Requirements
- R1: After reset: rdy_o=1, timer_o=0, read_mode_o=1, suspend_o=0 and erase_set_o=0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 start a chip erase. From the cycle after the last write: rdy_o=0, timer_o=1, read_mode_o=0 and erase_set_o is all ones. This state lasts ERASE_CYC cycles.
- R3: The same five leading writes followed by 0x30 at any address start a sector erase on sector addr_i[AW-1:AW-3] (the top bits, for 8 sectors). From the next cycle: rdy_o=0, timer_o=0, read_mode_o=0, and only that sector's bit is set in erase_set_o.
- R4: The acceptance window lasts WIN_CYC cycles without writes. A 0x30 write inside the window adds its sector in any order, up to all sectors, and restarts the full window.
- R5: Any write inside the window whose data is neither 0x30 nor 0xB0 returns the block to read-array mode in the next cycle, with erase_set_o cleared and rdy_o=1.
- R6: When the window expires, timer_o goes to 1 and the sector erase runs for ERASE_CYC cycles. During this time writes other than 0xB0 leave every output unchanged.
- R7: A 0xB0 write during the window or during a running sector erase sets suspend_o and changes nothing else. During a chip erase, all writes, including 0xB0, are ignored.
- R8: A write that does not match the next expected step of the unlock/setup sequence returns the block to read-array mode and affects no output. While in read-array mode, writes other than 0xAA@0x555 are ignored.
- R9: When the erase counter finishes, rdy_o=1, timer_o=0, read_mode_o=1, and erase_set_o and suspend_o are cleared.
- R10: Asserting rst_ni during any phase ends it at once, giving the R1 output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | AW | Write address |
| data_i | input | 8 | Write data / command byte |
| rdy_o | output | 1 | 1 = ready, 0 = busy |
| timer_o | output | 1 | 1 = acceptance window over, erase running |
| read_mode_o | output | 1 | 1 = idle in read-array mode |
| suspend_o | output | 1 | Suspend command recognised |
| erase_set_o | output | NSECT | Latched sectors to erase, one bit per sector |

## Verification
The assertions check on every cycle that:
- a running chip erase holds its state and set against any write;
- a running sector erase keeps its sector set;
- a foreign write in the window aborts;
- the set only grows while the window is open;
- completion releases everything.

Only the bench scenarios can show the exact lengths of the window and erase phases, the window restart on late additions, and out-of-order and full-set sector collection. The same holds for rejection at each position of the unlock sequence, and for abort by reset during each phase.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_SETUP, ST_U3, ST_U4, ST_SWIN, ST_SBUSY, ST_CBUSY
  } fe_state_e;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [11:0] ADR_UNLK1 = 12'h555;
  localparam logic [11:0] ADR_UNLK2 = 12'h2AA;
endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode import fe_pkg::*; #(
  parameter int AW = 12,
  parameter int SW = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          unlk1_o,
  output logic          unlk2_o,
  output logic          setup_o,
  output logic          chip_o,
  output logic          sect_o,
  output logic          susp_o,
  output logic [SW-1:0] sect_idx_o
);
  logic a555, a2aa;
  assign a555       = (addr_i == AW'(ADR_UNLK1));
  assign a2aa       = (addr_i == AW'(ADR_UNLK2));
  assign unlk1_o    = a555 && (data_i == CMD_UNLK1);
  assign unlk2_o    = a2aa && (data_i == CMD_UNLK2);
  assign setup_o    = a555 && (data_i == CMD_SETUP);
  assign chip_o     = a555 && (data_i == CMD_CHIP);
  assign sect_o     = (data_i == CMD_SECT);
  assign susp_o     = (data_i == CMD_SUSP);
  assign sect_idx_o = addr_i[AW-1 -: SW];
endmodule

// File: rtl/fe_down_counter.sv
module fe_down_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6: an exhausted counter never wraps
  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && en_i && !load_i) |=> zero_o);
endmodule

// File: rtl/flash_erase_decoder.sv
module flash_erase_decoder import fe_pkg::*; #(
  parameter int AW        = 12,
  parameter int NSECT     = 8,
  parameter int WIN_CYC   = 20,
  parameter int ERASE_CYC = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       data_i,
  output logic             rdy_o,
  output logic             timer_o,
  output logic             read_mode_o,
  output logic             suspend_o,
  output logic [NSECT-1:0] erase_set_o
);
  localparam int SW = $clog2(NSECT);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int EW = $clog2(ERASE_CYC + 1);

  fe_state_e        state_q, state_d;
  logic [NSECT-1:0] set_q, set_d, sect_oh;
  logic             susp_q, susp_d;
  logic             win_load, win_en, win_zero;
  logic             ers_load, ers_en, ers_zero;
  logic             is_unlk1, is_unlk2, is_setup, is_chip, is_sect, is_susp;
  logic [SW-1:0]    sect_idx;

  fe_cmd_decode #(.AW(AW), .SW(SW)) u_dec (
    .addr_i(addr_i), .data_i(data_i),
    .unlk1_o(is_unlk1), .unlk2_o(is_unlk2), .setup_o(is_setup),
    .chip_o(is_chip), .sect_o(is_sect), .susp_o(is_susp),
    .sect_idx_o(sect_idx)
  );

  assign sect_oh = NSECT'(1) << sect_idx;

  always_comb begin
    state_d  = state_q;
    set_d    = set_q;
    susp_d   = susp_q;
    win_load = 1'b0;
    ers_load = 1'b0;
    unique case (state_q)
      ST_READ:  if (we_i && is_unlk1) state_d = ST_U1;
      ST_U1:    if (we_i) state_d = is_unlk2 ? ST_U2 : ST_READ;
      ST_U2:    if (we_i) state_d = is_setup ? ST_SETUP : ST_READ;
      ST_SETUP: if (we_i) state_d = is_unlk1 ? ST_U3 : ST_READ;
      ST_U3:    if (we_i) state_d = is_unlk2 ? ST_U4 : ST_READ;
      ST_U4: if (we_i) begin
        if (is_chip) begin
          state_d  = ST_CBUSY;
          set_d    = '1;
          ers_load = 1'b1;
        end else if (is_sect) begin
          state_d  = ST_SWIN;
          set_d    = sect_oh;
          win_load = 1'b1;
        end else begin
          state_d  = ST_READ;
        end
      end
      ST_SWIN: begin
        if (we_i) begin
          if (is_sect) begin
            set_d    = set_q | sect_oh;
            win_load = 1'b1;  // late sector restarts window
          end else if (is_susp) begin
            susp_d   = 1'b1;
          end else begin
            state_d  = ST_READ;
            set_d    = '0;
            susp_d   = 1'b0;
          end
        end else if (win_zero) begin
          state_d  = ST_SBUSY;
          ers_load = 1'b1;
        end
      end
      ST_SBUSY: begin
        if (ers_zero) begin
          state_d = ST_READ;
          set_d   = '0;
          susp_d  = 1'b0;
        end else if (we_i && is_susp) begin
          susp_d  = 1'b1;
        end
      end
      ST_CBUSY: if (ers_zero) begin
        state_d = ST_READ;
        set_d   = '0;
      end
      default: state_d = ST_READ;
    endcase
  end

  assign win_en = (state_q == ST_SWIN) && !we_i;
  assign ers_en = (state_q == ST_SBUSY) || (state_q == ST_CBUSY);

  fe_down_counter #(.W(WW)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(win_load),
    .load_val_i(WW'(WIN_CYC - 1)), .en_i(win_en), .zero_o(win_zero)
  );

  fe_down_counter #(.W(EW)) u_ers (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ers_load),
    .load_val_i(EW'(ERASE_CYC - 1)), .en_i(ers_en), .zero_o(ers_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      set_q   <= '0;
      susp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      set_q   <= set_d;
      susp_q  <= susp_d;
    end
  end

  assign rdy_o       = !(state_q inside {ST_SWIN, ST_SBUSY, ST_CBUSY});
  assign timer_o     = (state_q == ST_SBUSY) || (state_q == ST_CBUSY);
  assign read_mode_o = (state_q == ST_READ);
  assign suspend_o   = susp_q;
  assign erase_set_o = set_q;

  p_chip_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CBUSY && !ers_zero) |=> (state_q == ST_CBUSY && erase_set_o == '1 && !suspend_o));

  p_sbusy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SBUSY && !ers_zero) |=> (timer_o && $stable(erase_set_o)));

  p_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWIN && we_i && !is_sect && !is_susp) |=> (read_mode_o && rdy_o && erase_set_o == '0));

  p_set_grow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWIN) |=> (((erase_set_o & $past(erase_set_o)) == $past(erase_set_o)) || read_mode_o));

  p_done_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_o && ers_zero) |=> (rdy_o && read_mode_o && erase_set_o == '0 && !suspend_o));
endmodule

// File: tb/sim_flash_erase_decoder.sv
module sim_flash_erase_decoder;
  localparam int AW = 12, NSECT = 8, WIN = 20, ERS = 50;

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic rdy, timer, rmode, susp;
  logic [NSECT-1:0] eset;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  flash_erase_decoder #(.AW(AW), .NSECT(NSECT), .WIN_CYC(WIN), .ERASE_CYC(ERS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .data_i(data),
    .rdy_o(rdy), .timer_o(timer), .read_mode_o(rmode), .suspend_o(susp), .erase_set_o(eset)
  );

  // behavioural model: 0 read, 1..5 sequence steps, 6 window, 7 sector erase, 8 chip erase
  int ms, left;
  bit [NSECT-1:0] mset;
  bit msusp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; left = 0; mset = '0; msusp = 0;
    end else begin
      int sec;
      sec = int'(addr) / (4096 / NSECT);
      case (ms)
        0: if (we && addr == 12'h555 && data == 8'hAA) ms = 1;
        1: if (we) ms = (addr == 12'h2AA && data == 8'h55) ? 2 : 0;
        2: if (we) ms = (addr == 12'h555 && data == 8'h80) ? 3 : 0;
        3: if (we) ms = (addr == 12'h555 && data == 8'hAA) ? 4 : 0;
        4: if (we) ms = (addr == 12'h2AA && data == 8'h55) ? 5 : 0;
        5: if (we) begin
          if (addr == 12'h555 && data == 8'h10) begin ms = 8; left = ERS; mset = '1; end
          else if (data == 8'h30) begin ms = 6; left = WIN; mset = '0; mset[sec] = 1'b1; end
          else ms = 0;
        end
        6: begin
          if (we) begin
            if (data == 8'h30) begin mset[sec] = 1'b1; left = WIN; end
            else if (data == 8'hB0) msusp = 1;
            else begin ms = 0; mset = '0; msusp = 0; end
          end else if (left == 1) begin ms = 7; left = ERS; end
          else left--;
        end
        7, 8: begin
          if (left == 1) begin ms = 0; mset = '0; msusp = 0; end
          else begin
            left--;
            if (ms == 7 && we && data == 8'hB0) msusp = 1;
          end
        end
        default: ms = 0;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NSECT+3:0] act, exp;
      act = {rdy, timer, rmode, susp, eset};
      exp = {ms < 6, ms >= 7, ms == 0, msusp, mset};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s cycle compare: actual=%h expected=%h", cur_req, act, exp);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    we = 1; addr = a; data = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seq(logic [AW-1:0] a, logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, d);
  endtask

  task automatic do_reset();
    rst_n = 0; idle(2); rst_n = 1; idle(1);
  endtask

  initial begin
    idle(2); rst_n = 1; idle(1);
    cur_req = "R1";
    chk("R1 reset outputs", {rdy, timer, rmode, susp, 24'(eset)}, {4'b1010, 24'h0});

    cur_req = "R2";
    seq(12'h555, 8'h10);
    chk("R2 chip busy", {rdy, timer, rmode, 24'(eset)}, {3'b010, 24'hFF});
    cur_req = "R7";
    wr(12'h555, 8'hB0); wr(12'h555, 8'hAA); wr(12'h000, 8'h30);
    chk("R7 chip erase ignores writes", {susp, 24'(eset), timer}, {1'b0, 24'hFF, 1'b1});
    idle(ERS - 6);
    chk("R2 still busy near end", rdy, 0);
    idle(4);
    cur_req = "R9";
    chk("R9 chip done", {rdy, timer, rmode, 24'(eset)}, {3'b101, 24'h0});

    cur_req = "R3";
    seq(12'hE00, 8'h30);
    chk("R3 sector 7 latched", {rdy, timer, rmode, 24'(eset)}, {3'b000, 24'h80});
    idle(WIN - 1);
    chk("R4 window still open", timer, 0);
    idle(1);
    cur_req = "R6";
    chk("R6 erase begun", {timer, rdy}, 2'b10);
    wr(12'h200, 8'h30); wr(12'h555, 8'hF0);
    chk("R6 writes ignored in erase", {24'(eset), rmode}, {24'h80, 1'b0});
    cur_req = "R7";
    wr(12'h000, 8'hB0);
    chk("R7 suspend flagged in erase", {susp, timer}, 2'b11);
    idle(ERS);
    cur_req = "R9";
    chk("R9 sector done", {rdy, rmode, susp, 24'(eset)}, {3'b110, 24'h0});

    cur_req = "R4";
    seq(12'hA00, 8'h30);
    idle(WIN - 3); wr(12'h200, 8'h30);
    idle(WIN - 3); wr(12'h600, 8'h30);
    chk("R4 window restarted", {timer, 24'(eset)}, {1'b0, 24'h2A});
    wr(12'h000, 8'h30); wr(12'hE00, 8'h30); wr(12'h400, 8'h30);
    wr(12'h800, 8'h30); wr(12'hC00, 8'h30);
    chk("R4 all sectors", {timer, 24'(eset)}, {1'b0, 24'hFF});
    idle(WIN + ERS + 2);
    chk("R4 done", rmode, 1);

    cur_req = "R5";
    seq(12'h400, 8'h30);
    idle(3);
    wr(12'h100, 8'hF0);
    chk("R5 abort", {rdy, rmode, 24'(eset)}, {2'b11, 24'h0});

    cur_req = "R7";
    seq(12'h400, 8'h30);
    wr(12'h000, 8'hB0);
    chk("R7 suspend in window", {susp, timer, 24'(eset)}, {2'b10, 24'h04});
    idle(WIN + ERS + 2);
    chk("R9 suspend cleared", {susp, rmode}, 2'b01);

    cur_req = "R8";
    for (int k = 0; k < 5; k++) begin
      if (k > 0) wr(12'h555, 8'hAA);
      if (k > 1) wr(12'h2AA, 8'h55);
      if (k > 2) wr(12'h555, 8'h80);
      if (k > 3) wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h30);
      chk("R8 mismatch returns to read", {rmode, rdy, 24'(eset)}, {2'b11, 24'h0});
    end
    wr(12'h555, 8'h10);
    chk("R8 lone command ignored", {rmode, rdy}, 2'b11);

    cur_req = "R10";
    seq(12'h600, 8'h30);
    idle(WIN + 3);
    do_reset();
    chk("R10 reset in sector erase", {rdy, timer, rmode, susp, 24'(eset)}, {4'b1010, 24'h0});
    seq(12'h555, 8'h10);
    idle(5);
    do_reset();
    chk("R10 reset in chip erase", {rdy, timer, rmode, susp, 24'(eset)}, {4'b1010, 24'h0});

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule